// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block sits on the host side of an asynchronous DRAM that takes its address on multiplexed pins and holds read data until the next column strobe falls. A host issues word or byte reads and writes on a valid/ready port. Each request carries a 20-bit word address and two byte-lane enables. Read data comes back as a one-cycle pulse on a response port. The controller drives the row strobe, one column strobe per byte lane, the write strobe and the read output enable. It drives a 10-bit multiplexed address, and it drives the outgoing half of a 16-bit data bus together with that bus's enable. The pad ring outside the block joins the bus halves.

After an access, the row stays open. A later request to the same row runs only a column cycle, and a request to another row first precharges and then opens the new row. All analog timing minimums are given in nanoseconds and converted into clock counts from the clock period. A separate refresh and power-up block asks for the pins with a request line. The controller closes the open row and grants the pins, but only between host requests.

Top module: `edo_page_ctrl`

## Requirements
- R1: During reset, all strobes (row, both column lanes, write, read enable) are high, the data bus enable is low, and neither a response nor a refresh grant is asserted.
- R2: The address is split as row = req_addr[19:10] and column = req_addr[9:0]. The row value is on mem_ma when the row strobe falls, and the column value is on mem_ma when the column strobe falls.
- R3: req_be[0] selects the low lane (data bits 7:0, strobe mem_col_stb_n[0]) and req_be[1] selects the high lane (bits 15:8, strobe mem_col_stb_n[1]). Only the strobes of the enabled lanes fall.
- R4: For a write, mem_wr_n is low, mem_dq_oe is high and mem_dq_out carries the request data in the cycle before the column strobe falls, and they stay that way while it is low.
- R5: For a read, mem_wr_n stays high and mem_rd_en_n is low in the cycle before the column strobe falls. mem_dq_oe is never high while mem_rd_en_n is low.
- R6: For each read, rsp_valid pulses for one cycle after the column precharge phase. rsp_rdata holds the bus value sampled in the last cycle of that phase, and the lanes that were not enabled read as zero.
- R7: A request to the row that is already open causes no new fall of the row strobe.
- R8: A request to a different row raises the row strobe, keeps it high for at least RP cycles, and then opens the new row.
- R9: Once the row strobe falls, it stays low for at least RAS cycles.
- R10: A column strobe falls more than RCD cycles after the row strobe falls. It stays low for exactly CAS cycles and stays high for at least CP cycles between pulses.
- R11: While ref_req is high, the controller closes any open row and asserts ref_gnt, with all strobes high and the bus enable low. It accepts no request while the grant is held. The first access after the grant ends opens a row again.
- R12: req_ready is high only when no access is in progress and no refresh is requested, and it drops in the cycle after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in upper half |
| req_be | input | 2 | Byte-lane enables |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data pulse |
| rsp_rdata | output | 16 | Read data |
| ref_req | input | 1 | Refresh block wants the pins |
| ref_gnt | output | 1 | Pins handed over, row closed |
| mem_row_stb_n | output | 1 | Row strobe, active low |
| mem_col_stb_n | output | 2 | Column strobe per lane, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_rd_en_n | output | 1 | Read output enable, active low |
| mem_ma | output | 10 | Multiplexed row/column address |
| mem_dq_out | output | 16 | Outgoing data |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 16 | Incoming data from the pads |

## Verification
The embedded properties assume that req_be is never zero when req_valid is high, that the host holds its request stable until it is accepted, and that ref_req is never dropped to admit a request in the same cycle a request is presented. The stimulus sends only nonzero lane masks and holds every request until it sees req_ready. It withdraws req_valid before it releases ref_req. A behavioural DRAM model in the bench latches the row and column on strobe edges and holds read data until the next column fall, so early sampling or a wrong lane mask shows up as a data mismatch.

// File: rtl/edo_pkg.sv
package edo_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ROW,
      ST_RCD,
      ST_COL,
      ST_CAS,
      ST_CP,
      ST_CLOSE,
      ST_PRE,
      ST_REF
   } edo_st_e;

   function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/edo_tmr.sv
module edo_tmr #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         done
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/edo_row_trk.sv
module edo_row_trk #(
   parameter int ROW_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_set,
   input  logic             close,
   input  logic [ROW_W-1:0] row_in,
   input  logic [ROW_W-1:0] cmp_row,
   output logic             is_open,
   output logic             hit
);

   logic             open_q;
   logic [ROW_W-1:0] row_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         row_q  <= '0;
      end else if (open_set) begin
         open_q <= 1'b1;
         row_q  <= row_in;
      end else if (close) begin
         open_q <= 1'b0;
      end
   end

   assign is_open = open_q;
   assign hit     = open_q && (cmp_row == row_q);

   // R8: opening and closing never collide in one cycle
   p_set_clr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(open_set && close));

   // R7: a row only opens from the closed state
   p_open_from_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      open_set |-> !open_q);

endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
   import edo_pkg::*;
#(
   parameter int CLK_NS   = 10,
   parameter int T_RAS_NS = 60,
   parameter int T_RP_NS  = 40,
   parameter int T_RCD_NS = 45,
   parameter int T_CAS_NS = 15,
   parameter int T_CP_NS  = 10,
   parameter int ROW_W    = 10,
   parameter int COL_W    = 10,
   parameter int DATA_W   = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic                     req_write,
   input  logic [ROW_W+COL_W-1:0]   req_addr,
   input  logic [DATA_W/8-1:0]      req_be,
   input  logic [DATA_W-1:0]        req_wdata,
   output logic                     rsp_valid,
   output logic [DATA_W-1:0]        rsp_rdata,
   input  logic                     ref_req,
   output logic                     ref_gnt,
   output logic                     mem_row_stb_n,
   output logic [DATA_W/8-1:0]      mem_col_stb_n,
   output logic                     mem_wr_n,
   output logic                     mem_rd_en_n,
   output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] mem_ma,
   output logic [DATA_W-1:0]        mem_dq_out,
   output logic                     mem_dq_oe,
   input  logic [DATA_W-1:0]        mem_dq_in
);

   localparam int ADDR_W  = ROW_W + COL_W;
   localparam int MA_W    = (ROW_W > COL_W) ? ROW_W : COL_W;
   localparam int LANES   = DATA_W / 8;
   localparam int RAS_CYC = ns2cyc(T_RAS_NS, CLK_NS);
   localparam int RP_CYC  = ns2cyc(T_RP_NS, CLK_NS);
   localparam int RCD_CYC = ns2cyc(T_RCD_NS, CLK_NS);
   localparam int CAS_CYC = ns2cyc(T_CAS_NS, CLK_NS);
   localparam int CP_CYC  = ns2cyc(T_CP_NS, CLK_NS);
   localparam int MAXC    = max2(max2(RAS_CYC, RP_CYC), max2(max2(RCD_CYC, CAS_CYC), CP_CYC));
   localparam int TW      = $clog2(MAXC + 1);

   // elaboration-time parameter checks
   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
      initial $fatal(1, "data width must be a whole number of bytes");
   end
   if (RAS_CYC < 1 || RP_CYC < 1 || RCD_CYC < 1 || CAS_CYC < 1 || CP_CYC < 1) begin : g_bad_timing
      initial $fatal(1, "every timing minimum must be at least one clock");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      initial $fatal(1, "clock period must be positive");
   end

   edo_st_e st_q, st_d;

   logic             accept, is_open, hit, row_set, row_clr;
   logic             st_ld, st_done, ras_ld, ras_ok;
   logic [TW-1:0]    st_val;
   logic             wr_q, pend_q, cap;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;
   logic [LANES-1:0] be_q;
   logic [DATA_W-1:0] wdata_q;
   logic             cur_wr;
   logic [LANES-1:0] cur_be;
   logic [ROW_W-1:0] cur_row;
   logic [COL_W-1:0] cur_col;
   logic [ROW_W-1:0] req_row;
   logic [COL_W-1:0] req_col;
   logic             we_n_q, oe_n_q, dq_oe_q, rsp_q;
   logic [MA_W-1:0]  ma_q;

   assign req_row = req_addr[ADDR_W-1:COL_W];
   assign req_col = req_addr[COL_W-1:0];

   edo_tmr #(.W(TW)) u_step (
      .clk(clk), .rst_n(rst_n), .load(st_ld), .val(st_val), .done(st_done)
   );

   edo_tmr #(.W(TW)) u_rasmin (
      .clk(clk), .rst_n(rst_n), .load(ras_ld), .val(TW'(RAS_CYC - 1)), .done(ras_ok)
   );

   edo_row_trk #(.ROW_W(ROW_W)) u_row (
      .clk(clk), .rst_n(rst_n), .open_set(row_set), .close(row_clr),
      .row_in(row_q), .cmp_row(req_row), .is_open(is_open), .hit(hit)
   );

   assign req_ready = (st_q == ST_IDLE) && !ref_req;
   assign ref_gnt   = (st_q == ST_REF);

   always_comb begin
      st_d    = st_q;
      accept  = 1'b0;
      st_ld   = 1'b0;
      st_val  = '0;
      row_set = 1'b0;
      row_clr = 1'b0;
      ras_ld  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (ref_req) begin
               st_d = is_open ? ST_CLOSE : ST_REF;
            end else if (req_valid) begin
               accept = 1'b1;
               if (!is_open)  st_d = ST_ROW;
               else if (hit)  st_d = ST_COL;
               else           st_d = ST_CLOSE;
            end
         end
         ST_ROW: begin
            st_d    = ST_RCD;
            row_set = 1'b1;
            ras_ld  = 1'b1;
            st_ld   = 1'b1;
            st_val  = TW'(RCD_CYC - 1);
         end
         ST_RCD: if (st_done) st_d = ST_COL;
         ST_COL: begin
            st_d   = ST_CAS;
            st_ld  = 1'b1;
            st_val = TW'(CAS_CYC - 1);
         end
         ST_CAS: if (st_done) begin
            st_d   = ST_CP;
            st_ld  = 1'b1;
            st_val = TW'(CP_CYC - 1);
         end
         ST_CP: if (st_done) st_d = ST_IDLE;
         ST_CLOSE: if (ras_ok) begin
            st_d    = ST_PRE;
            row_clr = 1'b1;
            st_ld   = 1'b1;
            st_val  = TW'(RP_CYC - 1);
         end
         ST_PRE: if (st_done) st_d = pend_q ? ST_ROW : ST_IDLE;
         ST_REF: if (!ref_req) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   assign cur_wr  = accept ? req_write : wr_q;
   assign cur_be  = accept ? req_be    : be_q;
   assign cur_row = accept ? req_row   : row_q;
   assign cur_col = accept ? req_col   : col_q;
   assign cap     = (st_q == ST_CP) && st_done && !wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         wr_q    <= 1'b0;
         pend_q  <= 1'b0;
         row_q   <= '0;
         col_q   <= '0;
         be_q    <= '0;
         wdata_q <= '0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            wr_q    <= req_write;
            pend_q  <= 1'b1;
            row_q   <= req_row;
            col_q   <= req_col;
            be_q    <= req_be;
            wdata_q <= req_wdata;
         end else if (st_q == ST_CP && st_done) begin
            pend_q  <= 1'b0;
         end
      end
   end

   // pin registers, each a function of the next state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_n_q  <= 1'b1;
         oe_n_q  <= 1'b1;
         dq_oe_q <= 1'b0;
         ma_q    <= '0;
         rsp_q   <= 1'b0;
      end else begin
         we_n_q  <= !((st_d == ST_COL || st_d == ST_CAS) && cur_wr);
         dq_oe_q <=  ((st_d == ST_COL || st_d == ST_CAS) && cur_wr);
         oe_n_q  <= !((st_d == ST_COL || st_d == ST_CAS || st_d == ST_CP) && !cur_wr);
         if (st_d == ST_ROW)      ma_q <= MA_W'(cur_row);
         else if (st_d == ST_COL) ma_q <= MA_W'(cur_col);
         rsp_q   <= cap;
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic       cas_n_l;
      logic [7:0] rd_l;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cas_n_l <= 1'b1;
            rd_l    <= '0;
         end else begin
            cas_n_l <= !(st_d == ST_CAS && cur_be[i]);
            if (cap) rd_l <= be_q[i] ? mem_dq_in[i*8 +: 8] : 8'h00;
         end
      end
      assign mem_col_stb_n[i]   = cas_n_l;
      assign rsp_rdata[i*8 +: 8] = rd_l;
   end

   assign mem_row_stb_n = !is_open;
   assign mem_wr_n      = we_n_q;
   assign mem_rd_en_n   = oe_n_q;
   assign mem_dq_oe     = dq_oe_q;
   assign mem_dq_out    = wdata_q;
   assign mem_ma        = ma_q;
   assign rsp_valid     = rsp_q;

   // R5: bus drive and read enable never overlap
   p_bus_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_rd_en_n);

   // R10: a column strobe is only low inside an open row
   p_col_in_row_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_col_stb_n != '1) |-> !mem_row_stb_n);

   // R9: the row strobe only rises after the minimum low time has run out
   p_ras_min_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_row_stb_n) |-> $past(ras_ok));

   // R4: a write column fall finds write strobe and bus drive already set
   p_early_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mem_col_stb_n) == '1 && mem_col_stb_n != '1 && !mem_wr_n)
         |-> ($past(mem_wr_n) == 1'b0 && $past(mem_dq_oe) == 1'b1));

   // R11: the granted pins are quiet
   p_gnt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ref_gnt |-> (mem_row_stb_n && mem_col_stb_n == '1 && !mem_dq_oe && !req_ready));

   // R6: a read response lasts one cycle
   p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R12: while ready, no column cycle is in flight
   p_ready_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_col_stb_n == '1 && mem_wr_n));

endmodule

// File: tb/tb_edo_page_ctrl.sv
module tb_edo_page_ctrl;

   localparam int CLK_P = 10;
   localparam int RAS_C = 6;
   localparam int RP_C  = 4;
   localparam int RCD_C = 5;
   localparam int CAS_C = 2;
   localparam int CP_C  = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [19:0] req_addr = '0;
   logic [1:0]  req_be = 2'b11;
   logic [15:0] req_wdata = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic        ref_req = 1'b0;
   logic        ref_gnt;
   logic        mem_row_stb_n;
   logic [1:0]  mem_col_stb_n;
   logic        mem_wr_n, mem_rd_en_n;
   logic [9:0]  mem_ma;
   logic [15:0] mem_dq_out;
   logic        mem_dq_oe;
   logic [15:0] mem_dq_in = '0;

   always #(CLK_P/2) clk = ~clk;

   edo_page_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .ref_req(ref_req), .ref_gnt(ref_gnt),
      .mem_row_stb_n(mem_row_stb_n), .mem_col_stb_n(mem_col_stb_n),
      .mem_wr_n(mem_wr_n), .mem_rd_en_n(mem_rd_en_n), .mem_ma(mem_ma),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   int total = 0;
   int bad   = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   typedef struct {
      bit          wr;
      int          row;
      int          col;
      logic [1:0]  be;
      logic [15:0] d;
   } acc_t;

   acc_t        acc_q[$];
   logic [15:0] rsp_exp_q[$];
   logic [15:0] dmem[int];
   logic [15:0] gold[int];

   int ras_falls = 0;
   int exp_falls = 0;
   bit exp_open  = 1'b0;
   int exp_row   = 0;

   function automatic logic [15:0] seed_val(input int k);
      return 16'((k * 37) ^ 16'h5A5A);
   endfunction

   function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                         input logic [1:0] be);
      logic [15:0] r;
      r = old;
      if (be[0]) r[7:0]  = d[7:0];
      if (be[1]) r[15:8] = d[15:8];
      return r;
   endfunction

   // behavioural DRAM device and pin-level monitor
   logic       p_ras = 1'b1, p_we = 1'b1, p_oe = 1'b1, p_dqoe = 1'b0, p_rsp = 1'b0;
   logic [1:0] p_cas = 2'b11;
   int  ras_lo = 0, ras_hi = 0, cas_lo = 0, cas_hi = 0;
   int  dev_row = 0;
   bit  ras_seen = 1'b0, cas_seen = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (p_ras && !mem_row_stb_n) begin
            ras_falls++;
            if (ras_seen) chk(ras_hi >= RP_C, "R8", "precharge cycles", ras_hi, RP_C);
            ras_seen = 1'b1;
            if (acc_q.size() > 0)
               chk(int'(mem_ma) == acc_q[0].row, "R2", "row address", mem_ma, acc_q[0].row);
            dev_row = int'(mem_ma);
            ras_lo = 0;
         end
         if (!p_ras && mem_row_stb_n) begin
            chk(ras_lo >= RAS_C, "R9", "row low cycles", ras_lo, RAS_C);
            ras_hi = 0;
         end
         if (p_cas == 2'b11 && mem_col_stb_n != 2'b11) begin
            chk(acc_q.size() > 0, "R3", "column cycle without request", acc_q.size(), 1);
            if (acc_q.size() > 0) begin
               acc_t a;
               int   k;
               a = acc_q.pop_front();
               k = dev_row * 1024 + int'(mem_ma);
               chk(int'(mem_ma) == a.col, "R2", "column address", mem_ma, a.col);
               chk(~mem_col_stb_n == a.be, "R3", "lane strobes", ~mem_col_stb_n, a.be);
               chk(ras_lo > RCD_C, "R10", "row to column cycles", ras_lo, RCD_C + 1);
               if (cas_seen) chk(cas_hi >= CP_C, "R10", "column high cycles", cas_hi, CP_C);
               if (a.wr) begin
                  chk(!p_we && p_dqoe && !mem_wr_n, "R4", "early write setup",
                      {p_we, p_dqoe, mem_wr_n}, 3'b010);
                  chk(mem_dq_out == a.d, "R4", "write data", mem_dq_out, a.d);
                  dmem[k] = merge(dmem.exists(k) ? dmem[k] : seed_val(k), mem_dq_out, ~mem_col_stb_n);
               end else begin
                  logic [15:0] v;
                  chk(!p_oe && mem_wr_n && !mem_dq_oe, "R5", "read setup",
                      {p_oe, mem_wr_n, mem_dq_oe}, 3'b010);
                  v = dmem.exists(k) ? dmem[k] : seed_val(k);
                  mem_dq_in[7:0]  = !mem_col_stb_n[0] ? v[7:0]  : 8'hEE;
                  mem_dq_in[15:8] = !mem_col_stb_n[1] ? v[15:8] : 8'hEE;
               end
            end
            cas_seen = 1'b1;
            cas_lo = 0;
         end
         if (p_cas != 2'b11 && mem_col_stb_n == 2'b11) begin
            chk(cas_lo == CAS_C, "R10", "column low cycles", cas_lo, CAS_C);
            cas_hi = 0;
         end
         if (rsp_valid) begin
            chk(!p_rsp, "R6", "response width", p_rsp, 0);
            chk(rsp_exp_q.size() > 0, "R6", "unexpected response", rsp_exp_q.size(), 1);
            if (rsp_exp_q.size() > 0) begin
               logic [15:0] e;
               e = rsp_exp_q.pop_front();
               chk(rsp_rdata == e, "R6", "read data", rsp_rdata, e);
            end
         end
         if (mem_row_stb_n) ras_hi++; else ras_lo++;
         if (mem_col_stb_n == 2'b11) cas_hi++; else cas_lo++;
      end
      p_ras  = mem_row_stb_n;
      p_cas  = mem_col_stb_n;
      p_we   = mem_wr_n;
      p_oe   = mem_rd_en_n;
      p_dqoe = mem_dq_oe;
      p_rsp  = rsp_valid;
   end

   task automatic do_req(input bit wr, input int row, input int col,
                         input logic [1:0] be, input logic [15:0] d);
      acc_t  a;
      int    k;
      string tag;
      logic [15:0] cur;
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = {row[9:0], col[9:0]};
      req_be    = be;
      req_wdata = d;
      while (!req_ready) @(negedge clk);
      k   = row * 1024 + col;
      cur = gold.exists(k) ? gold[k] : seed_val(k);
      if (wr) begin
         gold[k] = merge(cur, d, be);
      end else begin
         rsp_exp_q.push_back(cur & {{8{be[1]}}, {8{be[0]}}});
      end
      tag = (exp_open && exp_row == row) ? "R7" : "R8";
      if (!(exp_open && exp_row == row)) exp_falls++;
      exp_open = 1'b1;
      exp_row  = row;
      a.wr = wr; a.row = row; a.col = col; a.be = be; a.d = d;
      acc_q.push_back(a);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R12", "ready after accept", req_ready, 0);
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      chk(ras_falls == exp_falls, tag, "row opens", ras_falls, exp_falls);
   endtask

   task automatic do_refresh();
      int w;
      int falls0;
      @(negedge clk);
      ref_req = 1'b1;
      w = 0;
      while (!ref_gnt && w < 60) begin
         @(negedge clk);
         w++;
      end
      chk(ref_gnt, "R11", "grant given", ref_gnt, 1);
      chk(mem_row_stb_n && mem_col_stb_n == 2'b11 && !mem_dq_oe, "R11", "pins quiet",
          {mem_row_stb_n, mem_col_stb_n, mem_dq_oe}, 4'b1110);
      falls0 = ras_falls;
      req_valid = 1'b1;
      req_write = 1'b0;
      req_addr  = 20'h00005;
      req_be    = 2'b11;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(!req_ready, "R11", "ready during grant", req_ready, 0);
      end
      req_valid = 1'b0;
      chk(ras_falls == falls0 && mem_row_stb_n, "R11", "no access during grant", ras_falls, falls0);
      @(negedge clk);
      ref_req = 1'b0;
      exp_open = 1'b0;
      @(negedge clk);
      chk(!ref_gnt && req_ready, "R11", "grant released", {ref_gnt, req_ready}, 2'b01);
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(mem_row_stb_n && mem_col_stb_n == 2'b11 && mem_wr_n && mem_rd_en_n,
          "R1", "strobes in reset", {mem_row_stb_n, mem_col_stb_n, mem_wr_n, mem_rd_en_n}, 5'h1F);
      chk(!mem_dq_oe && !rsp_valid && !ref_gnt, "R1", "outputs in reset",
          {mem_dq_oe, rsp_valid, ref_gnt}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready, "R12", "ready after reset", req_ready, 1);

      do_req(1'b1, 5, 3, 2'b11, 16'h1234);
      do_req(1'b0, 5, 3, 2'b11, 16'h0);
      do_req(1'b1, 5, 3, 2'b01, 16'h77AB);
      do_req(1'b0, 5, 3, 2'b11, 16'h0);
      do_req(1'b1, 5, 3, 2'b10, 16'hCD99);
      do_req(1'b0, 5, 3, 2'b10, 16'h0);
      do_req(1'b0, 5, 3, 2'b01, 16'h0);
      do_req(1'b1, 5, 1023, 2'b11, 16'hBEEF);
      do_req(1'b1, 5, 0, 2'b11, 16'h0F0F);
      do_req(1'b0, 5, 1023, 2'b11, 16'h0);
      do_req(1'b0, 5, 0, 2'b11, 16'h0);
      do_req(1'b0, 9, 77, 2'b11, 16'h0);
      do_req(1'b1, 9, 77, 2'b11, 16'hA5A5);

      do_refresh();
      do_req(1'b0, 9, 77, 2'b11, 16'h0);
      do_refresh();
      do_refresh();

      for (int i = 0; i < 6; i++) begin
         do_req(1'b0, (i % 2 == 1) ? 1023 : 0, i * 100, 2'b11, 16'h0);
      end
      do_req(1'b1, 1023, 1023, 2'b11, 16'hFACE);
      do_req(1'b0, 1023, 1023, 2'b11, 16'h0);
      do_req(1'b1, 0, 1, 2'b10, 16'h3C00);
      do_req(1'b0, 0, 1, 2'b11, 16'h0);

      repeat (5) @(negedge clk);
      chk(rsp_exp_q.size() == 0, "R6", "responses outstanding", rsp_exp_q.size(), 0);
      chk(acc_q.size() == 0, "R3", "column cycles outstanding", acc_q.size(), 0);
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog R12 act=%0d exp=%0d", 150000, 0);
      summary();
      $finish;
   end

endmodule